// File: doc/BRIEF.md
# Byte-Wise SEC-DED Protected Word Memory

This block is a synchronous model of a 16-bit-wide static memory in which each byte lane is kept with its own five-bit check field. On a write, each enabled byte is encoded into a 13-bit extended Hamming codeword and stored in that lane's array. On a read, each lane's codeword is decoded. A single flipped bit is repaired before the data leaves the block. Two flipped bits are reported but cannot be repaired. The results of the selected lanes are folded into a two-flag status.

The access controls are active low: chip select, write enable, output enable, and an enable for each byte lane. Reads return data one clock after the request, with a valid bit per lane. After reset, the block stays not-ready for a parameterised number of cycles, standing in for a power-up initialisation interval, and ignores every access until that count is done. A fault port lets a test flip chosen bits of the codewords as they are written.

Top module: `ecc_sram16`

## Requirements
- R1: A write is a cycle with cs_n=0 and we_n=0. lb_n=0 stores wdata[7:0] and ub_n=0 stores wdata[15:8] at addr. A lane whose enable is high keeps its earlier data and check bits.
- R2: A read is a cycle with cs_n=0 and we_n=1. One clock later, lane 0 (rdata[7:0], rvalid[0]) is driven only if oe_n=0 and lb_n=0. Lane 1 (rdata[15:8], rvalid[1]) is driven only if oe_n=0 and ub_n=0. A lane that is not driven shows zero data with its valid bit low.
- R3: A write cycle produces no read data and no error status in the following cycle, even when oe_n is low.
- R4: When cs_n=1, no access takes place, and the following cycle shows rvalid=0 and err_valid=0.
- R5: A single flipped bit anywhere in a lane's 13-bit codeword is corrected on read, and err_single is raised.
- R6: Two flipped bits in a lane's codeword raise err_double on read. That lane's data is treated as invalid: its rvalid bit is low and its data reads zero.
- R7: The flags merge across lanes as follows. {err_single, err_double}=00 means no error. 10 means only corrected singles. 01 means only double errors. 11 means one lane was corrected and the other had a double error.
- R8: Only lanes enabled for the read contribute to the error flags. A damaged lane that is not selected raises no flag.
- R9: A read with oe_n=1 drives no lane, and err_valid, err_single and err_double stay low.
- R10: After rst falls, ready rises exactly INIT_CYCLES clock edges later and then stays high. Until ready is high, writes store nothing and reads return nothing.
- R11: A write with fault_en=1 XORs fault_flip[12:0] into the lower lane's codeword and fault_flip[25:13] into the upper lane's codeword before they are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | output | 1 | Initialisation interval complete |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| fault_en | input | 1 | Apply fault_flip on this write |
| fault_flip | input | 26 | Codeword bits to invert, 13 per lane |
| rdata | output | 16 | Read data, one cycle after the read |
| rvalid | output | 2 | Per-lane read data valid |
| err_valid | output | 1 | Error flags are being driven |
| err_single | output | 1 | Corrected single-bit error seen |
| err_double | output | 1 | Uncorrectable double-bit error seen |

## Verification
The case that needs care is a single read in which one lane is corrected and the other lane is declared invalid. In that cycle, correction and invalidation happen on separate lanes, and both flags must be raised together. To set this up, the bench writes words through the fault port with a one-bit flip in one lane and a two-bit flip in the other, in both arrangements. It then reads them back with both lanes enabled and expects the status 11, good data on the repaired lane, and a low valid bit on the damaged lane. The same words are then read with only one lane enabled, or with oe_n high. This confirms that the flag from the unselected or disabled lane disappears.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int BYTE_W = 8;
  localparam int SYN_W  = 4;
  localparam int CHK_W  = SYN_W + 1;
  localparam int CW_W   = BYTE_W + CHK_W;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;

  typedef logic [CW_W-1:0] cw_t;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              single;
    logic              dbl;
  } dec_t;

  // Bit 0 holds overall parity; positions 1..12 form a Hamming code
  // with check bits at the power-of-two positions.
  function automatic cw_t secded_encode(input logic [BYTE_W-1:0] d);
    cw_t  cw;
    int   k;
    logic b;
    cw = '0;
    k  = 0;
    for (int i = 1; i < CW_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        cw[i] = d[k];
        k++;
      end
    end
    for (int p = 0; p < SYN_W; p++) begin
      b = 1'b0;
      for (int i = 1; i < CW_W; i++) begin
        if (((i >> p) & 1) == 1 && i != (1 << p)) b = b ^ cw[i];
      end
      cw[1 << p] = b;
    end
    cw[0] = ^cw[CW_W-1:1];
    return cw;
  endfunction

  function automatic dec_t secded_decode(input cw_t cw);
    dec_t           r;
    cw_t            fx;
    logic [SYN_W-1:0] syn;
    logic           par;
    int             k;
    syn = '0;
    for (int i = 1; i < CW_W; i++) begin
      if (cw[i]) syn = syn ^ SYN_W'(i);
    end
    par      = ^cw;
    fx       = cw;
    r.single = 1'b0;
    r.dbl    = 1'b0;
    if (par) begin
      if (syn == '0) begin
        fx[0]    = ~fx[0];
        r.single = 1'b1;
      end else if (int'(syn) < CW_W) begin
        fx[syn]  = ~fx[syn];
        r.single = 1'b1;
      end else begin
        r.dbl = 1'b1;
      end
    end else if (syn != '0) begin
      r.dbl = 1'b1;
    end
    r.data = '0;
    k      = 0;
    for (int i = 1; i < CW_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        r.data[k] = fx[i];
        k++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_init_timer.sv
module ecc_init_timer #(
  parameter int INIT_CYCLES = 37500
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(INIT_CYCLES - 1)) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_lane.sv
module ecc_lane
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [CW_W-1:0]   flip,
  output dec_t              result
);
  localparam int DEPTH = 1 << ADDR_W;

  cw_t mem [DEPTH];
  cw_t wr_cw;
  cw_t rd_q;

  always_comb wr_cw = secded_encode(wbyte) ^ flip;

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_cw;
    if (rd_en) rd_q <= mem[addr];
  end

  always_comb result = secded_decode(rd_q);
endmodule

// File: rtl/ecc_sram16.sv
module ecc_sram16
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int INIT_CYCLES = 37500
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic                  ready,
  input  logic                  cs_n,
  input  logic                  we_n,
  input  logic                  oe_n,
  input  logic                  ub_n,
  input  logic                  lb_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  input  logic                  fault_en,
  input  logic [LANES*CW_W-1:0] fault_flip,
  output logic [WORD_W-1:0]     rdata,
  output logic [LANES-1:0]      rvalid,
  output logic                  err_valid,
  output logic                  err_single,
  output logic                  err_double
);
  logic             active;
  logic             do_wr;
  logic             do_rd;
  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] sel_q;
  logic [LANES-1:0] lane_single;
  logic [LANES-1:0] lane_dbl;
  dec_t             dec [LANES];

  ecc_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .ready (ready)
  );

  always_comb begin
    active  = ready && !cs_n;
    do_wr   = active && !we_n;
    do_rd   = active && we_n;
    lane_en = {~ub_n, ~lb_n};
  end

  // Lanes whose data will be driven in the cycle after a read.
  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= (do_rd && !oe_n) ? lane_en : '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ecc_lane #(.ADDR_W(ADDR_W)) u_lane (
      .clk    (clk),
      .wr_en  (do_wr && lane_en[g]),
      .rd_en  (do_rd),
      .addr   (addr),
      .wbyte  (wdata[g*BYTE_W +: BYTE_W]),
      .flip   (fault_en ? fault_flip[g*CW_W +: CW_W] : '0),
      .result (dec[g])
    );

    always_comb begin
      lane_single[g]               = sel_q[g] && dec[g].single;
      lane_dbl[g]                  = sel_q[g] && dec[g].dbl;
      rvalid[g]                    = sel_q[g] && !dec[g].dbl;
      rdata[g*BYTE_W +: BYTE_W]    = rvalid[g] ? dec[g].data : '0;
    end
  end

  always_comb begin
    err_valid  = |sel_q;
    err_single = |lane_single;
    err_double = |lane_dbl;
  end
endmodule

// File: rtl/ecc_sram16_chk.sv
module ecc_sram16_chk #(
  parameter int ADDR_W = 10
) (
  input logic        clk,
  input logic        rst,
  input logic        ready,
  input logic        cs_n,
  input logic        we_n,
  input logic        oe_n,
  input logic        lb_n,
  input logic        ub_n,
  input logic [15:0] rdata,
  input logic [1:0]  rvalid,
  input logic        err_valid,
  input logic        err_single,
  input logic        err_double
);
  // R10
  quiet_before_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (rvalid == 2'b00 && !err_valid));
  // R10
  ready_holds_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  // R4
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (rvalid == 2'b00 && !err_valid));
  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !we_n) |=> (rvalid == 2'b00 && !err_valid));
  // R9
  oe_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (rvalid == 2'b00 && !err_valid && !err_single && !err_double));
  // R2
  low_lane_src_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid[0] |-> $past(!cs_n && we_n && !oe_n && !lb_n));
  // R2
  high_lane_src_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid[1] |-> $past(!cs_n && we_n && !oe_n && !ub_n));
  // R7
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (err_single || err_double) |-> err_valid);
  // R6
  dead_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!rvalid[0] |-> rdata[7:0] == 8'h00) and (!rvalid[1] |-> rdata[15:8] == 8'h00));
endmodule

bind ecc_sram16 ecc_sram16_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ready      (ready),
  .cs_n       (cs_n),
  .we_n       (we_n),
  .oe_n       (oe_n),
  .lb_n       (lb_n),
  .ub_n       (ub_n),
  .rdata      (rdata),
  .rvalid     (rvalid),
  .err_valid  (err_valid),
  .err_single (err_single),
  .err_double (err_double)
);

// File: tb/sim_ecc_sram16.sv
module sim_ecc_sram16;
  localparam int AW   = 6;
  localparam int INIT = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ready;
  logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic          fault_en = 1'b0;
  logic [25:0]   fault_flip = '0;
  logic [15:0]   rdata;
  logic [1:0]    rvalid;
  logic          err_valid, err_single, err_double;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ecc_sram16 #(.ADDR_W(AW), .INIT_CYCLES(INIT)) u0 (
    .clk(clk), .rst(rst), .ready(ready), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata), .fault_en(fault_en),
    .fault_flip(fault_flip), .rdata(rdata), .rvalid(rvalid), .err_valid(err_valid),
    .err_single(err_single), .err_double(err_double)
  );

  typedef struct packed {
    logic        cs_n, we_n, oe_n, ub_n, lb_n;
    logic [5:0]  a;
    logic [15:0] wd;
    logic [25:0] flip;
    logic [15:0] er;
    logic [1:0]  ev;
    logic [2:0]  ef;   // {err_valid, err_single, err_double}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,6'd1,16'hA55A,26'h0,      16'h0000,2'b00,3'b000,4'd3},  // R3 write, oe low
    '{1'b0,1'b1,1'b0,1'b0,1'b0,6'd1,16'h0000,26'h0,      16'hA55A,2'b11,3'b100,4'd2},  // R2
    '{1'b0,1'b1,1'b0,1'b1,1'b0,6'd1,16'h0000,26'h0,      16'h005A,2'b01,3'b100,4'd2},  // R2 lower only
    '{1'b0,1'b1,1'b0,1'b0,1'b1,6'd1,16'h0000,26'h0,      16'hA500,2'b10,3'b100,4'd2},  // R2 upper only
    '{1'b0,1'b0,1'b1,1'b1,1'b0,6'd1,16'hFF33,26'h0,      16'h0000,2'b00,3'b000,4'd1},  // R1 lower write
    '{1'b0,1'b1,1'b0,1'b0,1'b0,6'd1,16'h0000,26'h0,      16'hA533,2'b11,3'b100,4'd1},  // R1 upper kept
    '{1'b0,1'b1,1'b1,1'b0,1'b0,6'd1,16'h0000,26'h0,      16'h0000,2'b00,3'b000,4'd9},  // R9
    '{1'b1,1'b1,1'b0,1'b0,1'b0,6'd1,16'h0000,26'h0,      16'h0000,2'b00,3'b000,4'd4},  // R4
    '{1'b0,1'b0,1'b1,1'b0,1'b0,6'd2,16'h1234,26'h8,      16'h0000,2'b00,3'b000,4'd11}, // R11
    '{1'b0,1'b1,1'b0,1'b0,1'b0,6'd2,16'h0000,26'h0,      16'h1234,2'b11,3'b110,4'd5},  // R5
    '{1'b0,1'b0,1'b1,1'b0,1'b0,6'd3,16'hBEEF,26'h0102000,16'h0000,2'b00,3'b000,4'd11}, // R11
    '{1'b0,1'b1,1'b0,1'b0,1'b0,6'd3,16'h0000,26'h0,      16'h00EF,2'b01,3'b101,4'd6},  // R6
    '{1'b0,1'b1,1'b0,1'b1,1'b0,6'd3,16'h0000,26'h0,      16'h00EF,2'b01,3'b100,4'd8},  // R8
    '{1'b0,1'b0,1'b1,1'b0,1'b0,6'd4,16'hC3A5,26'h3000001,16'h0000,2'b00,3'b000,4'd11}, // R11
    '{1'b0,1'b1,1'b0,1'b0,1'b0,6'd4,16'h0000,26'h0,      16'h00A5,2'b01,3'b111,4'd7},  // R7
    '{1'b0,1'b1,1'b0,1'b0,1'b1,6'd4,16'h0000,26'h0,      16'h0000,2'b00,3'b101,4'd8},  // R8
    '{1'b0,1'b0,1'b1,1'b0,1'b0,6'd5,16'h0F0F,26'h2000006,16'h0000,2'b00,3'b000,4'd11}, // R11
    '{1'b0,1'b1,1'b0,1'b0,1'b0,6'd5,16'h0000,26'h0,      16'h0F00,2'b10,3'b111,4'd7},  // R7
    '{1'b0,1'b1,1'b1,1'b0,1'b0,6'd5,16'h0000,26'h0,      16'h0000,2'b00,3'b000,4'd9},  // R9
    '{1'b0,1'b1,1'b0,1'b1,1'b1,6'd1,16'h0000,26'h0,      16'h0000,2'b00,3'b000,4'd2}   // R2 no lane
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic c, w, o, u, l, input logic [AW-1:0] a,
                       input logic [15:0] d, input logic [25:0] f);
    cs_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l; addr = a; wdata = d;
    fault_en = (f != '0); fault_flip = f;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ready in reset", int'(ready), 0);
    check("R10 rvalid in reset", int'(rvalid), 0);
    check("R10 err_valid in reset", int'(err_valid), 0);
    rst = 1'b0;
    repeat (INIT - 1) @(negedge clk);
    check("R10 ready one edge early", int'(ready), 0);
    @(negedge clk);
    check("R10 ready on time", int'(ready), 1);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i].cs_n, VT[i].we_n, VT[i].oe_n, VT[i].ub_n, VT[i].lb_n,
            VT[i].a, VT[i].wd, VT[i].flip);
      check($sformatf("R%0d vec%0d rdata", VT[i].req, i), int'(rdata), int'(VT[i].er));
      check($sformatf("R%0d vec%0d rvalid", VT[i].req, i), int'(rvalid), int'(VT[i].ev));
      check($sformatf("R%0d vec%0d flags", VT[i].req, i),
            int'({err_valid, err_single, err_double}), int'(VT[i].ef));
    end
    idle();

    // R10: accesses during the init interval are ignored
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd9, 16'h1234, '0);
    idle();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd9, 16'hFFFF, '0);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd9, 16'h0000, '0);
    check("R10 read while not ready", int'(rvalid), 0);
    repeat (INIT) @(negedge clk);
    check("R10 ready again", int'(ready), 1);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd9, 16'h0000, '0);
    check("R10 early write dropped", int'(rdata), 16'h1234);
    check("R10 read after init valid", int'(rvalid), 3);
    idle();
    finish_run();
  end
endmodule